// File: doc/BRIEF.md
# UART Receive Byte Buffer with Flow Control

This block stores bytes handed over by a serial receiver until a bus-side reader collects them. It is a sixteen-slot first-in first-out store with a write strobe from the receiver side and a read strobe from the reader side. The read data is registered and appears the cycle after an accepted read. Empty and full flags are driven straight from the stored count.

Two independent threshold comparators watch the count. Both take the same two-bit level code. The first drives a data-ready flag that tells the reader a batch is waiting. The second drives the request-to-send line used for hardware flow control. That line has a selectable active polarity. It can follow the count automatically or take its value from a software bit.

A byte offered while the store is full is lost. The loss is recorded in a sticky error flag until a clear strobe removes it.

Top module: `uart_rx_buf`

## Requirements
- R1: After reset the buffer is empty, `empty`=1, `full`=0, `data_rdy`=0, `ovf_err`=0 and `rd_data`=0.
- R2: Bytes leave in the order they were accepted. `rd_data` shows the oldest byte in the cycle after a `rd_en` cycle that found the buffer non-empty.
- R3: `empty` is 1 exactly when no byte is held. `full` is 1 exactly when DEPTH (16) bytes are held.
- R4: A `wr_en` while `full` is 1 is dropped, even when `rd_en` is high in the same cycle. The held bytes are not altered, and a same-cycle read still returns the oldest byte.
- R5: A dropped write sets `ovf_err` in the following cycle. `ovf_err` stays 1 until an `ovf_clr` pulse. A drop in the same cycle as the clear leaves it set.
- R6: A `rd_en` while `empty` is 1 leaves `rd_data` unchanged and does not move the read position. The next byte written is the next byte read.
- R7: The level code maps 0→1, 1→4, 2→8 and 3→14 bytes. `data_rdy` is 1 exactly when the held count is at least the level chosen by `rdy_lvl`.
- R8: With `rts_auto`=1, the line is asserted while the count is below the level chosen by `rts_lvl`. It is deasserted once the count reaches that level and asserted again when the count falls back below it.
- R9: With `rts_auto`=0, the line is asserted exactly when `rts_sw`=1.
- R10: Polarity follows `rts_act_low`. With 0, asserted drives `rts_pin`=1. With 1, asserted drives `rts_pin`=0.
- R11: A write and a read in the same cycle on a partly filled buffer both take effect and leave the count unchanged. On an empty buffer the read is ignored and the write is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte-received strobe from the receiver |
| wr_data | input | 8 | Received byte |
| rd_en | input | 1 | Read strobe from the bus side |
| rdy_lvl | input | 2 | Level code for the data-ready flag |
| rts_lvl | input | 2 | Level code for the flow-control line |
| rts_auto | input | 1 | 1: line follows count; 0: line follows `rts_sw` |
| rts_act_low | input | 1 | 1: line is active low; 0: active high |
| rts_sw | input | 1 | Software request when automatic control is off |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_data | output | 8 | Last byte read |
| empty | output | 1 | No byte held |
| full | output | 1 | DEPTH bytes held |
| data_rdy | output | 1 | Count at or above the data-ready level |
| rts_pin | output | 1 | Flow-control line |
| ovf_err | output | 1 | Sticky overflow flag |

## Verification
Every count-derived result is due one cycle after the write or read strobe: `empty`, `full`, `data_rdy` and an automatic `rts_pin` all follow the count register. `rd_data` and `ovf_err` are registers and are also due one edge later. The polarity and manual-request inputs reach `rts_pin` without a register. The bench drives all inputs on the falling edge, lets exactly one rising edge pass, and samples at the next falling edge, so each result is read in the first cycle it is due.

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [1:0]    rdy_lvl,
  input  logic [1:0]    rts_lvl,
  input  logic          rts_auto,
  input  logic          rts_act_low,
  input  logic          rts_sw,
  input  logic          ovf_clr,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic          data_rdy,
  output logic          rts_pin,
  output logic          ovf_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_wr, do_rd, ready;

  function automatic logic [CW-1:0] lvl_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return CW'(1);
      2'd1:    return CW'(4);
      2'd2:    return CW'(8);
      default: return CW'(14);
    endcase
  endfunction

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign do_wr    = wr_en && !full;
  assign do_rd    = rd_en && !empty;
  assign data_rdy = (count >= lvl_bytes(rdy_lvl));
  assign ready    = rts_auto ? (count < lvl_bytes(rts_lvl)) : rts_sw;
  assign rts_pin  = ready ^ rts_act_low;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      rd_data <= '0;
      ovf_err <= 1'b0;
    end else begin
      if (do_wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_rd) begin
        rptr    <= (rptr == LAST) ? '0 : rptr + 1'b1;
        rd_data <= mem[rptr];
      end
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_en && full) ovf_err <= 1'b1;
      else if (ovf_clr)  ovf_err <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R3
  AST_DROP_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> ovf_err); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err && !ovf_clr) |=> ovf_err); // R5
  AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> full); // R4
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> $stable(rd_data)); // R6
  AST_AUTO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_auto && full) |-> (rts_pin == rts_act_low)); // R8
endmodule

// File: tb/uart_rx_buf_tb_top.sv
module uart_rx_buf_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, ovf_clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] rdy_lvl = '0, rts_lvl = '0;
  logic rts_auto = 1'b1, rts_act_low = 1'b0, rts_sw = 1'b0;
  logic [7:0] rd_data;
  logic empty, full, data_rdy, rts_pin, ovf_err;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_rx_buf dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rdy_lvl(rdy_lvl), .rts_lvl(rts_lvl), .rts_auto(rts_auto),
    .rts_act_low(rts_act_low), .rts_sw(rts_sw), .ovf_clr(ovf_clr),
    .rd_data(rd_data), .empty(empty), .full(full), .data_rdy(data_rdy),
    .rts_pin(rts_pin), .ovf_err(ovf_err));

  // {rdy_lvl, rts_lvl, auto, act_low, sw, fill[4:0], exp_rdy, exp_pin}
  localparam int NV = 13;
  localparam logic [13:0] VEC [NV] = '{
    {2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0, 1'b1},
    {2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 5'd1,  1'b1, 1'b0},
    {2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 5'd3,  1'b0, 1'b0},
    {2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 5'd4,  1'b1, 1'b1},
    {2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 5'd7,  1'b0, 1'b1},
    {2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 5'd8,  1'b1, 1'b0},
    {2'd3, 2'd3, 1'b1, 1'b0, 1'b0, 5'd13, 1'b0, 1'b1},
    {2'd3, 2'd3, 1'b1, 1'b0, 1'b0, 5'd14, 1'b1, 1'b0},
    {2'd3, 2'd0, 1'b1, 1'b0, 1'b0, 5'd16, 1'b1, 1'b0},
    {2'd0, 2'd3, 1'b0, 1'b0, 1'b1, 5'd16, 1'b1, 1'b1},
    {2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 5'd0,  1'b0, 1'b0},
    {2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 5'd5,  1'b1, 1'b0},
    {2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 5'd0,  1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic cycle(input logic w, input logic [7:0] d, input logic r);
    @(negedge clk); wr_en = w; wr_data = d; rd_en = r;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 empty", 8'(empty), 8'd1);
    check("R1 full", 8'(full), 8'd0);
    check("R1 data_rdy", 8'(data_rdy), 8'd0);
    check("R1 ovf_err", 8'(ovf_err), 8'd0);
    check("R1 rd_data", rd_data, 8'h00);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      {rdy_lvl, rts_lvl, rts_auto, rts_act_low, rts_sw} = VEC[v][13:7];
      for (int k = 0; k < int'(VEC[v][6:2]); k++) cycle(1'b1, 8'(k), 1'b0);
      @(negedge clk);
      check($sformatf("R7 data_rdy vec%0d", v), 8'(data_rdy), 8'(VEC[v][1]));
      check($sformatf("R8 R9 R10 rts_pin vec%0d", v), 8'(rts_pin), 8'(VEC[v][0]));
    end

    // ordering, full, drop, sticky error
    rts_auto = 1'b1; rts_act_low = 1'b0; rdy_lvl = 2'd0; rts_lvl = 2'd1;
    do_reset();
    for (int k = 0; k < 16; k++) cycle(1'b1, 8'hA0 + 8'(k), 1'b0);
    check("R3 full at 16", 8'(full), 8'd1);
    check("R3 not empty", 8'(empty), 8'd0);
    cycle(1'b1, 8'hEE, 1'b0);
    check("R5 ovf_err set", 8'(ovf_err), 8'd1);
    check("R4 still full", 8'(full), 8'd1);
    for (int k = 0; k < 16; k++) begin
      cycle(1'b0, 8'h00, 1'b1);
      check("R2 R4 order", rd_data, 8'hA0 + 8'(k));
    end
    check("R3 empty after drain", 8'(empty), 8'd1);
    check("R5 ovf_err sticky", 8'(ovf_err), 8'd1);
    cycle(1'b0, 8'h00, 1'b1);
    check("R6 empty read holds", rd_data, 8'hAF);
    check("R6 still empty", 8'(empty), 8'd1);
    cycle(1'b1, 8'h5A, 1'b0);
    cycle(1'b0, 8'h00, 1'b1);
    check("R6 no pointer move", rd_data, 8'h5A);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    check("R5 cleared", 8'(ovf_err), 8'd0);

    // same-cycle read and write
    cycle(1'b1, 8'h11, 1'b0);
    cycle(1'b1, 8'h22, 1'b1);
    check("R11 rd while wr", rd_data, 8'h11);
    check("R11 count kept", 8'(empty), 8'd0);
    cycle(1'b0, 8'h00, 1'b1);
    check("R11 second byte", rd_data, 8'h22);
    check("R11 empty", 8'(empty), 8'd1);
    cycle(1'b1, 8'h33, 1'b1);
    check("R11 empty read ignored", rd_data, 8'h22);
    check("R11 write kept", 8'(empty), 8'd0);
    cycle(1'b0, 8'h00, 1'b1);
    check("R11 kept byte", rd_data, 8'h33);

    // full with simultaneous read and write; clear races a drop
    do_reset();
    for (int k = 0; k < 16; k++) cycle(1'b1, 8'h40 + 8'(k), 1'b0);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h99; rd_en = 1'b1; ovf_clr = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; ovf_clr = 1'b0;
    check("R4 read on full", rd_data, 8'h40);
    check("R4 write dropped", 8'(full), 8'd0);
    check("R5 drop beats clear", 8'(ovf_err), 8'd1);
    for (int k = 1; k < 16; k++) cycle(1'b0, 8'h00, 1'b1);
    check("R4 last byte intact", rd_data, 8'h4F);
    check("R4 drained", 8'(empty), 8'd1);

    // automatic hysteresis at level 4, active high
    rts_lvl = 2'd1;
    for (int k = 0; k < 4; k++) cycle(1'b1, 8'(k), 1'b0);
    check("R8 deasserted at level", 8'(rts_pin), 8'd0);
    cycle(1'b0, 8'h00, 1'b1);
    check("R8 reasserted below", 8'(rts_pin), 8'd1);
    rts_act_low = 1'b1;
    #1;
    check("R10 polarity flip", 8'(rts_pin), 8'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule